// File: doc/BRIEF.md
# AXI Write Request Bridge

This block is an AXI write slave placed in front of a packet-based link transmitter. A client presents a write burst on the address and data channels. The bridge checks the burst against its size and byte-strobe rules and passes each good beat, with the burst's address, class and tag, to a link-side request port. It then returns a response on the B channel.

The class input sampled with the address picks the handling. Memory writes are posted: their response is issued as soon as the last beat has been handed to the link. I/O and configuration writes are non-posted. Each one takes a tag in a small table of outstanding requests, and its response waits for a completion with that tag from the link side. Address acceptance is a one-cycle pulse. It is held off when the transmit-credit sideband is low, and also for non-posted writes when every tag is in use.

Top module: `awb_bridge`

## Requirements
- R1: `awReady` rises only while `awValid` and `creditOk` are both high, and it is never high in two consecutive cycles.
- R2: A non-posted write (class 1 = I/O, class 2 = configuration) is not accepted while all `TAG_DEPTH` tags are outstanding. A memory write (class 0) is still accepted in that state, and freeing a tag lets the held request through.
- R3: `wReady` stays low until a write address has been accepted, and only one burst is in its data phase at a time.
- R4: Each good beat is presented on `reqValid` with `reqStrb` equal to `wStrb` and `reqData` equal to `wData`. While `reqReady` is low, `wReady` stays low.
- R5: A burst with `awLen` nonzero and `awSize` other than 5 is answered with SLVERR. Its beats are drained with `wReady` high and none is forwarded. A single-beat burst may use any size.
- R6: Strobes must be contiguous and nonzero. A middle beat must be all ones. The first beat of a multi-beat burst must include the top byte, and the last beat must include byte 0. The beat that breaks a rule and every later beat of the burst are dropped, and the response is SLVERR.
- R7: A burst ends at the first beat that has `wLast` high or is beat `awLen`. If `wLast` does not fall on beat `awLen`, that beat is dropped and the response is SLVERR.
- R8: A memory write receives its B response after its last beat has been taken, with `bId` equal to its `awId`. `bResp` is 0 (OKAY) for a clean burst and 2 (SLVERR) for a faulty one.
- R9: A clean non-posted write carries one beat and takes the lowest free tag, shown on `reqTag`. No B response is issued until a completion with that tag arrives. That completion frees the tag and returns the stored ID, with SLVERR if `cplErr` is set. A completion for a free tag is ignored.
- R10: A non-posted write with `awLen` nonzero, or with more than four strobe bits set, and any write of class 3, receives SLVERR and takes no tag.
- R11: Once `bValid` is high, it stays high with `bResp` and `bId` unchanged until `bReady` is sampled high.
- R12: After reset, `awReady`, `wReady`, `bValid` and `reqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | One-cycle address accept pulse |
| awAddr | input | ADDR_W | Write start address |
| awLen | input | 8 | Beats minus one |
| awSize | input | 3 | log2 of bytes per beat |
| awClass | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 reserved |
| awId | input | ID_W | Transaction ID echoed on B |
| creditOk | input | 1 | Link transmit credit is available |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| wData | input | DATA_W | Write data |
| wStrb | input | DATA_W/8 | Byte strobes |
| wLast | input | 1 | Last beat marker |
| bValid | output | 1 | Response valid |
| bReady | input | 1 | Response accepted |
| bResp | output | 2 | 0 OKAY, 2 SLVERR |
| bId | output | ID_W | Response ID |
| reqValid | output | 1 | Link request beat valid |
| reqReady | input | 1 | Link takes the beat |
| reqAddr | output | ADDR_W | Burst address |
| reqClass | output | 2 | Burst class |
| reqTag | output | TAG_W | Tag for a non-posted burst |
| reqData | output | DATA_W | Beat data |
| reqStrb | output | DATA_W/8 | Beat strobes |
| reqLast | output | 1 | Final beat of the burst |
| cplValid | input | 1 | Link completion valid |
| cplReady | output | 1 | Completion taken |
| cplTag | input | TAG_W | Completion tag |
| cplErr | input | 1 | Completion carries an error status |

## Verification
The hardest state to reach from the ports is a full tag table with a request held at the address channel. Every tag has to stay allocated while posted traffic keeps moving, and a completion then has to free one slot so the held request can enter. The bench issues `TAG_DEPTH` I/O writes and withholds their completions. It checks that a further I/O request is refused while a memory write still goes through. It then completes one tag and checks that the next non-posted write reuses that tag. After that it drains the rest of the table, comparing each response ID against the write that owned the tag.

// File: rtl/awb_pkg.sv
package awb_pkg;
  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_IO  = 2'd1,
    CLS_CFG = 2'd2,
    CLS_RSV = 2'd3
  } wrClass_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptAw;
    logic takeBeat;
    logic endBurst;
    logic allocTag;
    logic loadPostB;
    logic takeCpl;
  } ctrlStrb_t;

  function automatic logic isNonPosted(input logic [1:0] cls);
    return (cls == CLS_IO) || (cls == CLS_CFG);
  endfunction
endpackage

// File: rtl/awb_ctrl.sv
module awb_ctrl
  import awb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      awValid,
  input  logic      awNp,
  input  logic      creditOk,
  input  logic      tableFull,
  output logic      awReady,
  input  logic      wValid,
  input  logic      wLast,
  input  logic      expLast,
  input  logic      beatBad,
  input  logic      dropBurst,
  input  logic      burstNp,
  output logic      wReady,
  output logic      reqValid,
  input  logic      reqReady,
  input  logic      bValid,
  input  logic      cplValid,
  output logic      cplReady,
  output ctrlStrb_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_RESP} state_e;
  state_e state, stateNext;
  logic skipBeat;

  always_comb begin
    skipBeat      = dropBurst || beatBad;
    awReady       = (state == ST_IDLE) && awValid && creditOk && !(awNp && tableFull);
    reqValid      = (state == ST_DATA) && wValid && !skipBeat;
    wReady        = (state == ST_DATA) && (skipBeat || reqReady);
    cplReady      = !bValid && (state != ST_RESP);
    strb.acceptAw  = awReady;
    strb.takeBeat  = wValid && wReady;
    strb.endBurst  = strb.takeBeat && (wLast || expLast);
    strb.allocTag  = strb.endBurst && burstNp && !skipBeat;
    strb.loadPostB = (state == ST_RESP) && !bValid;
    strb.takeCpl   = cplValid && cplReady;
    stateNext = state;
    case (state)
      ST_IDLE: if (awReady) stateNext = ST_DATA;
      ST_DATA: if (strb.endBurst) stateNext = strb.allocTag ? ST_IDLE : ST_RESP;
      ST_RESP: if (strb.loadPostB) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R1
  aw_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    awReady |=> !awReady);
endmodule

// File: rtl/awb_datapath.sv
module awb_datapath
  import awb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 256,
  parameter int ID_W      = 4,
  parameter int TAG_DEPTH = 4,
  localparam int STRB_W    = DATA_W / 8,
  localparam int TAG_W     = $clog2(TAG_DEPTH),
  localparam int BEAT_SIZE = $clog2(STRB_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [7:0]        awLen,
  input  logic [2:0]        awSize,
  input  logic [1:0]        awClass,
  input  logic [ID_W-1:0]   awId,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wLast,
  input  logic              bReady,
  input  logic [TAG_W-1:0]  cplTag,
  input  logic              cplErr,
  output logic              tableFull,
  output logic              expLast,
  output logic              beatBad,
  output logic              dropBurst,
  output logic              burstNp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqClass,
  output logic [TAG_W-1:0]  reqTag,
  output logic              bValid,
  output logic [1:0]        bResp,
  output logic [ID_W-1:0]   bId
);
  logic [ADDR_W-1:0]  addrQ;
  logic [7:0]         lenQ, beatCnt;
  logic [1:0]         clsQ;
  logic [ID_W-1:0]    idQ;
  logic [TAG_W-1:0]   tagQ, freeTag;
  logic               addrErrQ, stickyQ, burstOpen;
  logic [TAG_DEPTH-1:0] tblValid;
  logic [ID_W-1:0]    tblId [TAG_DEPTH];
  logic               firstBeat, shapeOk;

  function automatic logic contiguous(input logic [STRB_W-1:0] s);
    logic [STRB_W-1:0] low;
    low = s & (~s + 1'b1);
    return (s != '0) && (((s + low) & s) == '0);
  endfunction

  always_comb begin
    freeTag = '0;
    for (int i = TAG_DEPTH - 1; i >= 0; i--)
      if (!tblValid[i]) freeTag = i[TAG_W-1:0];
  end

  always_comb begin
    tableFull = &tblValid;
    burstNp   = isNonPosted(clsQ);
    dropBurst = addrErrQ || stickyQ;
    firstBeat = (beatCnt == 8'd0);
    expLast   = (beatCnt == lenQ);
    if (firstBeat && expLast) shapeOk = contiguous(wStrb);
    else if (firstBeat)       shapeOk = contiguous(wStrb) && wStrb[STRB_W-1];
    else if (expLast)         shapeOk = contiguous(wStrb) && wStrb[0];
    else                      shapeOk = &wStrb;
    beatBad = !shapeOk || (wLast != expLast) ||
              (burstNp && ($countones(wStrb) > 4));
    reqAddr  = addrQ;
    reqClass = clsQ;
    reqTag   = tagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; lenQ <= '0; clsQ <= '0; idQ <= '0; tagQ <= '0;
      addrErrQ <= 1'b0; stickyQ <= 1'b0; burstOpen <= 1'b0; beatCnt <= '0;
    end else begin
      if (strb.acceptAw) begin
        addrQ     <= awAddr;
        lenQ      <= awLen;
        clsQ      <= awClass;
        idQ       <= awId;
        tagQ      <= freeTag;
        addrErrQ  <= ((awLen != 8'd0) && (awSize != 3'(BEAT_SIZE))) ||
                     (isNonPosted(awClass) && (awLen != 8'd0)) ||
                     (awClass == CLS_RSV);
        stickyQ   <= 1'b0;
        beatCnt   <= '0;
        burstOpen <= 1'b1;
      end
      if (strb.takeBeat) begin
        beatCnt <= beatCnt + 8'd1;
        if (beatBad) stickyQ <= 1'b1;
      end
      if (strb.endBurst) burstOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblValid <= '0;
      for (int i = 0; i < TAG_DEPTH; i++) tblId[i] <= '0;
      bValid <= 1'b0; bResp <= RESP_OKAY; bId <= '0;
    end else begin
      if (bValid && bReady) bValid <= 1'b0;
      if (strb.takeCpl && tblValid[cplTag]) begin
        tblValid[cplTag] <= 1'b0;
        bValid <= 1'b1;
        bResp  <= cplErr ? RESP_SLVERR : RESP_OKAY;
        bId    <= tblId[cplTag];
      end
      if (strb.allocTag) begin
        tblValid[tagQ] <= 1'b1;
        tblId[tagQ]    <= idQ;
      end
      if (strb.loadPostB) begin
        bValid <= 1'b1;
        bResp  <= dropBurst ? RESP_SLVERR : RESP_OKAY;
        bId    <= idQ;
      end
    end
  end

  // R2
  np_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptAw && isNonPosted(awClass)) |-> !tableFull);
  // R3
  beat_after_aw_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeBeat |-> burstOpen);
  // R9
  no_double_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocTag |-> !tblValid[tagQ]);
  // R11
  b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bResp) && $stable(bId)));
endmodule

// File: rtl/awb_bridge.sv
module awb_bridge
  import awb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 256,
  parameter int ID_W      = 4,
  parameter int TAG_DEPTH = 4,
  localparam int STRB_W   = DATA_W / 8,
  localparam int TAG_W    = $clog2(TAG_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [7:0]        awLen,
  input  logic [2:0]        awSize,
  input  logic [1:0]        awClass,
  input  logic [ID_W-1:0]   awId,
  input  logic              creditOk,
  input  logic              wValid,
  output logic              wReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wLast,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp,
  output logic [ID_W-1:0]   bId,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqClass,
  output logic [TAG_W-1:0]  reqTag,
  output logic [DATA_W-1:0] reqData,
  output logic [STRB_W-1:0] reqStrb,
  output logic              reqLast,
  input  logic              cplValid,
  output logic              cplReady,
  input  logic [TAG_W-1:0]  cplTag,
  input  logic              cplErr
);
  ctrlStrb_t strb;
  logic tableFull, expLast, beatBad, dropBurst, burstNp;

  awb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awNp(isNonPosted(awClass)),
    .creditOk(creditOk), .tableFull(tableFull), .awReady(awReady),
    .wValid(wValid), .wLast(wLast), .expLast(expLast), .beatBad(beatBad),
    .dropBurst(dropBurst), .burstNp(burstNp), .wReady(wReady),
    .reqValid(reqValid), .reqReady(reqReady), .bValid(bValid),
    .cplValid(cplValid), .cplReady(cplReady), .strb(strb)
  );

  awb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .TAG_DEPTH(TAG_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .awAddr(awAddr), .awLen(awLen),
    .awSize(awSize), .awClass(awClass), .awId(awId), .wStrb(wStrb), .wLast(wLast),
    .bReady(bReady), .cplTag(cplTag), .cplErr(cplErr), .tableFull(tableFull),
    .expLast(expLast), .beatBad(beatBad), .dropBurst(dropBurst), .burstNp(burstNp),
    .reqAddr(reqAddr), .reqClass(reqClass), .reqTag(reqTag),
    .bValid(bValid), .bResp(bResp), .bId(bId)
  );

  assign reqData = wData;
  assign reqStrb = wStrb;
  assign reqLast = expLast;

  // R4
  link_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |-> !wReady);
  // R1
  aw_credit_chk: assert property (@(posedge clk) disable iff (!rstN)
    awReady |-> creditOk);
endmodule

// File: tb/awb_bridge_tb_top.sv
module awb_bridge_tb_top;
  localparam int DATA_W = 256;
  localparam int STRB_W = DATA_W / 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic awValid = 0, awReady, creditOk = 1, wValid = 0, wReady, wLast = 0;
  logic [31:0] awAddr = 0;
  logic [7:0] awLen = 0;
  logic [2:0] awSize = 5;
  logic [1:0] awClass = 0, bResp, reqClass;
  logic [3:0] awId = 0, bId;
  logic [DATA_W-1:0] wData = 0, reqData;
  logic [STRB_W-1:0] wStrb = 0, reqStrb;
  logic bValid, bReady = 0, reqValid, reqReady = 1, reqLast;
  logic [31:0] reqAddr;
  logic [1:0] reqTag, cplTag = 0;
  logic cplValid = 0, cplReady, cplErr = 0;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  awb_bridge dut_i (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .awLen(awLen), .awSize(awSize), .awClass(awClass), .awId(awId), .creditOk(creditOk),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bResp(bResp), .bId(bId),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqClass(reqClass),
    .reqTag(reqTag), .reqData(reqData), .reqStrb(reqStrb), .reqLast(reqLast),
    .cplValid(cplValid), .cplReady(cplReady), .cplTag(cplTag), .cplErr(cplErr)
  );

  typedef struct packed {
    logic [1:0]  cls;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [31:0] sFirst;
    logic [31:0] sLast;
    logic [7:0]  lastAt;
    logic        cErr;
    logic [1:0]  expResp;
    logic [7:0]  expFwd;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{2'd0, 8'd0, 3'd5, 32'h00FFFF00, 32'h0,        8'd0, 1'b0, 2'd0, 8'd1}, // R8 single beat
    '{2'd0, 8'd3, 3'd5, 32'hFFFF0000, 32'h000000FF, 8'd3, 1'b0, 2'd0, 8'd4}, // R6 partial ends
    '{2'd0, 8'd2, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd2, 1'b0, 2'd2, 8'd0}, // R5 bad size
    '{2'd0, 8'd0, 3'd2, 32'h0000000F, 32'h0,        8'd0, 1'b0, 2'd0, 8'd1}, // R5 len0 any size
    '{2'd0, 8'd2, 3'd5, 32'h0F0F0000, 32'hFFFFFFFF, 8'd2, 1'b0, 2'd2, 8'd0}, // R6 gap
    '{2'd0, 8'd2, 3'd5, 32'hFFFFFFFF, 32'hFF000000, 8'd2, 1'b0, 2'd2, 8'd2}, // R6 last misaligned
    '{2'd0, 8'd3, 3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd1, 1'b0, 2'd2, 8'd1}, // R7 early last
    '{2'd0, 8'd1, 3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd9, 1'b0, 2'd2, 8'd1}, // R7 missing last
    '{2'd1, 8'd0, 3'd5, 32'h0000000F, 32'h0,        8'd0, 1'b0, 2'd0, 8'd1}, // R9 io ok
    '{2'd2, 8'd0, 3'd5, 32'h00000FF0, 32'h0,        8'd0, 1'b0, 2'd2, 8'd0}, // R10 too wide
    '{2'd1, 8'd1, 3'd5, 32'h0000000F, 32'hFFFFFFFF, 8'd1, 1'b0, 2'd2, 8'd0}, // R10 np len
    '{2'd3, 8'd0, 3'd5, 32'h0000000F, 32'h0,        8'd0, 1'b0, 2'd2, 8'd0}, // R10 reserved
    '{2'd2, 8'd0, 3'd5, 32'h000000F0, 32'h0,        8'd0, 1'b1, 2'd2, 8'd1}  // R9 cpl error
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doAw(input logic [1:0] cls, input logic [7:0] len, input logic [2:0] sz,
                      input logic [3:0] id);
    awClass = cls; awLen = len; awSize = sz; awId = id; awAddr = {24'h0, id, 4'h0};
    awValid = 1;
    #1;
    while (!awReady) begin @(negedge clk); #1; end
    @(negedge clk);
    awValid = 0;
  endtask

  task automatic doBeat(input logic [STRB_W-1:0] s, input logic last,
                        output bit fwd, output logic [1:0] tag);
    wValid = 1; wStrb = s; wLast = last; wData = {8{$urandom()}};
    #1;
    while (!wReady) begin @(negedge clk); #1; end
    fwd = reqValid;
    tag = reqTag;
    if (fwd) check(reqStrb == s && reqData == wData, "R4 beat payload", reqStrb, s);
    @(negedge clk);
    wValid = 0; wLast = 0;
  endtask

  task automatic doCpl(input logic [1:0] tag, input logic err);
    cplValid = 1; cplTag = tag; cplErr = err;
    #1;
    while (!cplReady) begin @(negedge clk); #1; end
    @(negedge clk);
    cplValid = 0;
  endtask

  task automatic waitB(input logic [1:0] expResp, input logic [3:0] expId, input string req);
    bReady = 1;
    for (int k = 0; k < 40 && !bValid; k++) begin @(negedge clk); #1; end
    check(bValid && bResp == expResp && bId == expId, req, {bValid, bResp, bId}, {1'b1, expResp, expId});
    @(negedge clk);
    bReady = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    bit fwd;
    logic [1:0] tag;
    logic [1:0] tags [4];
    int nFwd;
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    check(!awReady && !wReady && !bValid && !reqValid, "R12 reset outputs",
          {awReady, wReady, bValid, reqValid}, 0);
    rstN = 1;
    @(negedge clk);

    // R3: data without an address is not taken
    wValid = 1; wStrb = '1; wLast = 1;
    for (int k = 0; k < 3; k++) begin
      #1; check(!wReady, "R3 no data before address", wReady, 0);
      @(negedge clk);
    end
    wValid = 0; wLast = 0;

    // vector table
    for (int i = 0; i < 13; i++) begin
      vec_t v = VECS[i];
      nFwd = 0;
      tag = 0;
      doAw(v.cls, v.len, v.size, 4'(i));
      for (int b = 0; b <= int'(v.len); b++) begin
        logic [31:0] s;
        logic [1:0] t;
        if (b == 0) s = v.sFirst;
        else if (b == int'(v.len)) s = v.sLast;
        else s = '1;
        doBeat(s, b == int'(v.lastAt), fwd, t);
        if (fwd) begin nFwd++; tag = t; end
        if (b == int'(v.lastAt)) break;
      end
      check(nFwd == int'(v.expFwd), "R5/R6/R7 forwarded beat count", nFwd, v.expFwd);
      if ((v.cls == 2'd1 || v.cls == 2'd2) && v.expFwd == 1) begin
        repeat (3) @(negedge clk);
        #1; check(!bValid, "R9 no response before completion", bValid, 0);
        doCpl(tag, v.cErr);
      end
      waitB(v.expResp, 4'(i), "R8/R9/R10 vector response");
    end

    // R1: credit gates the address, and accept lasts one cycle
    creditOk = 0; awClass = 0; awLen = 0; awSize = 5; awId = 4'd3; awValid = 1;
    for (int k = 0; k < 3; k++) begin
      #1; check(!awReady, "R1 held without credit", awReady, 0);
      @(negedge clk);
    end
    creditOk = 1;
    nFwd = 0;
    for (int k = 0; k < 4; k++) begin
      #1; if (awReady) nFwd++;
      @(negedge clk);
    end
    awValid = 0;
    check(nFwd == 1, "R1 single-cycle accept", nFwd, 1);
    doBeat('1, 1, fwd, tag);
    waitB(2'd0, 4'd3, "R1 response");

    // R4: link stall holds wReady low
    doAw(0, 1, 5, 4'd6);
    reqReady = 0; wValid = 1; wStrb = '1; wLast = 0;
    #1; check(!wReady && reqValid, "R4 stall", {wReady, reqValid}, 2'b01);
    @(negedge clk); #1;
    check(!wReady, "R4 stall second cycle", wReady, 0);
    reqReady = 1;
    doBeat('1, 0, fwd, tag);
    doBeat('1, 1, fwd, tag);
    check(fwd && !bValid, "R4 last beat forwarded", fwd, 1);
    waitB(2'd0, 4'd6, "R8 after stall");

    // R2: fill tag table
    for (int k = 0; k < 4; k++) begin
      doAw(1, 0, 5, 4'(10 + k));
      doBeat(32'h0000000F, 1, fwd, tags[k]);
    end
    check(tags[0] == 0 && tags[3] == 3, "R9 lowest free tag", tags[3], 3);
    awClass = 1; awLen = 0; awValid = 1;
    for (int k = 0; k < 4; k++) begin
      #1; check(!awReady, "R2 full table blocks np", awReady, 0);
      @(negedge clk);
    end
    awValid = 0;
    doAw(0, 0, 5, 4'd9);
    doBeat(32'h0000FFFF, 1, fwd, tag);
    waitB(2'd0, 4'd9, "R2 posted passes full table");
    doCpl(2'd3, 0);
    waitB(2'd0, 4'd13, "R9 completion returns id");
    doAw(1, 0, 5, 4'd14);
    doBeat(32'h000000F0, 1, fwd, tag);
    check(tag == 2'd3, "R2 freed tag reused", tag, 3);
    for (int k = 0; k < 3; k++) begin
      doCpl(2'(k), 0);
      waitB(2'd0, 4'(10 + k), "R9 drain");
    end
    // stray completion for a free tag is ignored
    doCpl(2'd0, 0);
    repeat (2) @(negedge clk);
    #1; check(!bValid, "R9 stray completion ignored", bValid, 0);
    doCpl(2'd3, 1);
    waitB(2'd2, 4'd14, "R9 error completion");

    // R11: response held until bReady
    doAw(0, 0, 5, 4'd7);
    doBeat(32'hFFFFFFFF, 1, fwd, tag);
    for (int k = 0; k < 10 && !bValid; k++) begin @(negedge clk); #1; end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(bValid && bResp == 0 && bId == 7, "R11 response held", {bValid, bId}, {1'b1, 4'd7});
    end
    bReady = 1;
    @(negedge clk); #1;
    bReady = 0;
    check(!bValid, "R11 released after bReady", bValid, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule